// File: doc/BRIEF.md
# Split-Register Four-Counter Performance Monitor

This block counts processor activity for profiling software. It holds one 32-bit cycle counter and four 32-bit event counters. Each event counter watches one of 256 single-cycle event pulse lines, and an 8-bit code chosen per counter selects that line. Software configures and reads the block through a small synchronous register port. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Control, interrupt enable, overflow status and event selection each sit in a separate register. The enable and status registers use the same per-counter bit order: bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3. A counter that wraps sets its status flag. A level interrupt stays high while any flag is set together with its enable bit. An optional divide-by-64 mode slows the cycle counter down for long measurements.

Register addresses: 0 control, 1 cycle count, 2 interrupt enable, 3 overflow flags, 4 event select, 5 to 8 event counters 0 to 3. Any other address reads zero, and writes to it are dropped.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, the registers read as follows. Control reads `{ID_CODE, 24'h0}`. All counters, the interrupt enable and the overflow flags read 0. Event select reads 0xFFFFFFFF. `irq` is low.
- R2: Control bit 0 is the run enable and bit 3 is divide-by-64; both keep the written value. Bit 1 and bit 2 are reset strobes and always read 0. Bits 23:4 always read 0. Bits 31:24 always read `ID_CODE`, whatever was written.
- R3: While the run enable is 0, no counter changes except by a direct write or a reset strobe.
- R4: With run set and divide-by-64 clear, the cycle counter adds one at every clock edge. The edge that clears run still counts.
- R5: With run and divide-by-64 both set, a 6-bit prescaler advances at every edge. The cycle counter adds one only at edges where the prescaler holds 63, which is once every 64 edges.
- R6: Event counter i adds one at each edge where run is set and `event_in[code_i]` is high. Its code `code_i` is the event-select field at bits 8i+7:8i.
- R7: An event code of 0xFF stops that counter, whatever the event lines are.
- R8: Writing control with bit 1 set clears all four event counters. Writing it with bit 2 set clears the cycle counter and the prescaler. Neither strobe changes the overflow flags.
- R9: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag. The flag is bit 0 for the cycle counter and bit 1+i for event counter i.
- R10: Writing a 1 to a bit of the flag register clears that flag, and writing a 0 leaves it as it is. If a wrap happens at the same edge as the clearing write, the flag stays set.
- R11: `irq` is high exactly while some flag bit and its interrupt-enable bit (same bit order) are both 1.
- R12: Every counter can be written directly at its address. The written value wins over a count at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| event_in | input | 256 | Event pulse lines, selected by code |
| irq | output | 1 | Level interrupt on enabled overflow |

## Verification
A register write shows on `reg_rdata` from the cycle after its edge. Counting starts at the first edge after the write that sets run. The edge that carries the write clearing run still adds one, so a run window of n port cycles yields exactly n counts. `irq` follows the flags with no added register. Every bench action takes one cycle between falling edges, so the expected values come from counting those actions, and the monitor compares each queued item just after the falling edge of the cycle in which the driver queued it.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int CNT_W   = 32;
  localparam int N_EVT   = 4;
  localparam int CODE_W  = 8;
  localparam int N_SLOT  = N_EVT + 1;
  localparam int N_SRC   = 2 ** CODE_W;
  localparam int SEL_W   = N_EVT * CODE_W;
  localparam int ADDR_W  = 4;
  localparam logic [CODE_W-1:0] CODE_OFF = '1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 4'd0,
    A_CYC  = 4'd1,
    A_IEN  = 4'd2,
    A_FLAG = 4'd3,
    A_SEL  = 4'd4,
    A_EVT0 = 4'd5
  } reg_addr_e;

  // pick the code field of one counter out of the packed select word
  function automatic logic [CODE_W-1:0] code_of(input logic [SEL_W-1:0] sel, input int idx);
    return sel[idx*CODE_W +: CODE_W];
  endfunction

  // sticky flags: new wraps win over write-one-to-clear
  function automatic logic [N_SLOT-1:0] flags_next(input logic [N_SLOT-1:0] cur,
                                                   input logic [N_SLOT-1:0] set,
                                                   input logic [N_SLOT-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/perfmon_prescaler.sv
module perfmon_prescaler #(
  parameter int PRESC_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic div,
  output logic tick
);
  logic [PRESC_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt <= '0;
    else if (clr)         pcnt <= '0;
    else if (run && div)  pcnt <= pcnt + 1'b1;
  end

  assign tick = run && (!div || (&pcnt));

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div && tick) |=> !(div && tick));
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign wrap = inc && !load && !clr && (&cnt);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load && !clr) |=> (cnt == $past(cnt)));

  // R12
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'h5C,
  parameter int         PRESC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [N_SRC-1:0]  event_in,
  output logic              irq
);
  logic wr_ctrl, wr_cyc, wr_ien, wr_flag, wr_sel;
  logic run_q, div_q;
  logic ev_clr, cyc_clr;
  logic cyc_tick;
  logic [N_SLOT-1:0] ien_q, flag_q, wrap_vec;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [CNT_W-1:0]  evt_cnt [N_EVT];
  logic [N_EVT-1:0]  wr_evt, evt_inc;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cyc  = reg_wr && (reg_addr == A_CYC);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign wr_sel  = reg_wr && (reg_addr == A_SEL);
  assign ev_clr  = wr_ctrl && reg_wdata[1];
  assign cyc_clr = wr_ctrl && reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      ien_q <= '0;
      sel_q <= '1;
      flag_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata[0];
        div_q <= reg_wdata[3];
      end
      if (wr_ien) ien_q <= reg_wdata[N_SLOT-1:0];
      if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
      flag_q <= flags_next(flag_q, wrap_vec, wr_flag ? reg_wdata[N_SLOT-1:0] : '0);
    end
  end

  perfmon_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .run(run_q), .div(div_q), .tick(cyc_tick)
  );

  perfmon_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .load(wr_cyc), .load_val(reg_wdata),
    .inc(cyc_tick), .cnt(cyc_cnt), .wrap(wrap_vec[0])
  );

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    logic [CODE_W-1:0] code_i;
    assign code_i    = code_of(sel_q, i);
    assign wr_evt[i] = reg_wr && (reg_addr == ADDR_W'(int'(A_EVT0) + i));
    assign evt_inc[i] = run_q && (code_i != CODE_OFF) && event_in[code_i];

    perfmon_counter #(.W(CNT_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .clr(ev_clr), .load(wr_evt[i]), .load_val(reg_wdata),
      .inc(evt_inc[i]), .cnt(evt_cnt[i]), .wrap(wrap_vec[i+1])
    );

    // R7
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == CODE_OFF && !wr_evt[i] && !ev_clr) |=> (evt_cnt[i] == $past(evt_cnt[i])));
  end

  assign irq = |(flag_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {ID_CODE, {(CNT_W-12){1'b0}}, div_q, 2'b00, run_q};
      A_CYC:   reg_rdata = cyc_cnt;
      A_IEN:   reg_rdata = CNT_W'(ien_q);
      A_FLAG:  reg_rdata = CNT_W'(flag_q);
      A_SEL:   reg_rdata = CNT_W'(sel_q);
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < N_EVT; i++)
      if (reg_addr == ADDR_W'(int'(A_EVT0) + i)) reg_rdata = evt_cnt[i];
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_flag_chk
    // R9
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[k] |=> flag_q[k]);
    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && reg_wdata[k] && !wrap_vec[k]) |=> !flag_q[k]);
    // R11
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_q[k]) && ien_q[k]) |-> irq);
  end
endmodule

// File: tb/perfmon_unit_tb_top.sv
module perfmon_unit_tb_top;
  import perfmon_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID = 8'h5C;

  logic clk, rst_n, reg_wr, irq;
  logic [ADDR_W-1:0] reg_addr;
  logic [CNT_W-1:0] reg_wdata, reg_rdata;
  logic [N_SRC-1:0] event_in;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  perfmon_unit #(.ID_CODE(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares queued items just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : reg_rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    sb_q.push_back('{1'b0, e, tag});
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb_q.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; event_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(4'd0, {ID, 24'h0}, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 cyc");
    rd(4'd2, 32'h0, "R1 ien");
    rd(4'd3, 32'h0, "R1 flags");
    rd(4'd4, 32'hFFFF_FFFF, "R1 evsel");
    for (int i = 0; i < 4; i++) rd(4'(5 + i), 32'h0, "R1 evcnt");
    chk_irq(1'b0, "R1 irq");

    // R2 control masking
    wr(4'd0, 32'hFFFF_FFF8);
    rd(4'd0, {ID, 20'h0, 4'b1000}, "R2 ctrl mask");
    wr(4'd0, 32'h0);
    rd(4'd0, {ID, 24'h0}, "R2 ctrl clear");

    // R3 nothing counts while stopped
    event_in = '1;
    wr(4'd4, 32'hC8FF_0703);
    idle(5);
    rd(4'd1, 32'h0, "R3 cyc stopped");
    rd(4'd5, 32'h0, "R3 evt0 stopped");
    rd(4'd4, 32'hC8FF_0703, "R6 evsel readback");

    // R4/R6/R7 ten counting edges
    event_in[200] = 1'b0;
    wr(4'd0, 32'h1);
    idle(9);
    wr(4'd0, 32'h0);
    rd(4'd1, 32'd10, "R4 cyc count");
    rd(4'd5, 32'd10, "R6 evt0 code3");
    rd(4'd6, 32'd10, "R6 evt1 code7");
    rd(4'd7, 32'd0, "R7 evt2 code FF");
    rd(4'd8, 32'd0, "R6 evt3 line low");
    idle(4);
    rd(4'd1, 32'd10, "R3 cyc holds");

    // R8 reset strobes
    wr(4'd0, 32'h2);
    rd(4'd5, 32'd0, "R8 evt0 cleared");
    rd(4'd6, 32'd0, "R8 evt1 cleared");
    rd(4'd1, 32'd10, "R8 cyc untouched");
    wr(4'd0, 32'h4);
    rd(4'd1, 32'd0, "R8 cyc cleared");
    rd(4'd0, {ID, 24'h0}, "R2 strobes read zero");

    // R5 divide-by-64: 130 enabled edges -> 2 ticks
    event_in = '0;
    wr(4'd0, 32'h9);
    rd(4'd0, {ID, 20'h0, 4'b1001}, "R2 ctrl div run");
    idle(128);
    wr(4'd0, 32'h0);
    rd(4'd1, 32'd2, "R5 div count");
    wr(4'd0, 32'h4);
    rd(4'd1, 32'd0, "R8 cyc cleared again");
    wr(4'd0, 32'h9);
    idle(61);
    wr(4'd0, 32'h0);
    rd(4'd1, 32'd0, "R5 prescaler cleared with cyc");
    rd(4'd3, 32'd0, "R8 flags untouched");

    // R12 direct loads
    wr(4'd1, 32'hFFFF_FFFD);
    wr(4'd5, 32'hFFFF_FFFE);
    rd(4'd1, 32'hFFFF_FFFD, "R12 cyc load");
    rd(4'd5, 32'hFFFF_FFFE, "R12 evt0 load");

    // R9/R11 wraps: 3 counting edges
    wr(4'd2, 32'h2);
    event_in = '1;
    event_in[200] = 1'b0;
    wr(4'd0, 32'h1);
    idle(2);
    wr(4'd0, 32'h0);
    rd(4'd3, 32'h3, "R9 flags cyc+evt0");
    rd(4'd1, 32'd0, "R9 cyc wrapped");
    rd(4'd5, 32'd1, "R9 evt0 wrapped");
    rd(4'd6, 32'd3, "R6 evt1 three");
    chk_irq(1'b1, "R11 irq on enabled flag");

    // R10/R11 write-one-to-clear
    wr(4'd3, 32'h2);
    rd(4'd3, 32'h1, "R10 clear bit1 only");
    chk_irq(1'b0, "R11 irq off when enabled flag cleared");
    wr(4'd2, 32'h1);
    chk_irq(1'b1, "R11 irq via cyc enable");
    wr(4'd3, 32'h1);
    chk_irq(1'b0, "R11 irq low after clear");
    rd(4'd3, 32'h0, "R10 flags empty");

    // R10 wrap at the same edge as a clearing write
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd0, 32'h1);
    wr(4'd3, 32'h2);
    wr(4'd0, 32'h0);
    rd(4'd3, 32'h2, "R10 set beats clear");
    rd(4'd5, 32'd1, "R12 evt0 after wrap");
    rd(4'd1, 32'd2, "R4 cyc two edges");
    chk_irq(1'b0, "R11 flag without enable");
    rd(4'd7, 32'd0, "R7 evt2 still zero");

    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule